// File: doc/BRIEF.md
# Multi-Comparator Toggle PWM Channel

This block produces one pulse-width-modulated output. The output is not built from a single duty-cycle compare. A 16-bit period counter advances once per prescaled clock tick. A bank of eight comparators each flips the output when the counter reaches its programmed value, so several pulses of different widths can be placed inside one period. When the counter wraps, the output restarts from a programmable initial level.

Software programs the channel through a byte-wide, write-only register bus. A channel index on the bus selects one instance when several copies of the block share the bus. All shaping values are held in shadow copies, which are loaded at the start of a run and at every period boundary. A write made in the middle of a period therefore never disturbs the waveform that is being produced.

A sticky interrupt flag is set at each period boundary. Software clears it by writing a one. The flag reaches the interrupt pin only when the interrupt enable bit is set.

The sequencer has two states:
- ST_IDLE: the counter is held at zero and the output follows the initial level.
- ST_RUN: the counter is counting.

The transitions are:
- START (ST_IDLE to ST_RUN): taken when the run bit is set. It loads the shadows.
- WRAP (ST_RUN to ST_RUN): taken when the counter passes its period value on a tick. It reloads the shadows and sets the interrupt flag.
- STOP (ST_RUN to ST_IDLE): taken when the run bit is cleared.

Top module: `tpwm_channel`

## Requirements
- R1: A bus write takes effect only when `wr_en` is high and `wr_chan` equals the parameter CHAN_ID. Writes carrying any other channel index change nothing.
- R1 (register map): address 0 is control, with bit0 run, bit1 initial level and bit2 interrupt enable. Address 1 is the prescale value. Address 2 is the period low byte and address 3 the period high byte. Address 4 holds the comparator enables, with bit k for comparator k. Address 5 is the interrupt clear. Comparator k has its low byte at address 8+2k and its high byte at address 9+2k.
- R2: With prescale value p, the counter advances exactly once every p+1 system clocks, and the output changes only on those ticks. p=0 gives one tick per clock and p=255 gives one tick per 256 clocks.
- R3: The counter runs from 0 up to the period value P and then wraps to 0. One output period therefore lasts (P+1)*(p+1) system clocks.
- R4: START: one clock after the run bit is written to 1, the counter is at 0 and the output equals the initial level, flipped once if an enabled comparator holds the value 0.
- R5: While the counter holds c, the output equals the initial level XOR the parity of the number of enabled comparators whose value lies in 0..c. Two enabled comparators with the same value therefore cancel. For example, toggles at 7, 8, 12, 14, 15, 16, 19 and 22 give four pulses.
- R6: A comparator that is disabled, or whose value exceeds the period, never toggles the output.
- R7: WRAP: at the period boundary the output returns to the initial level, flipped once by an enabled comparator at 0.
- R8: Writes to the period, prescale, comparator values and enables, and to the initial level, made during a period only take effect from the next period boundary.
- R9: STOP: one clock after the run bit is written to 0, the output equals the initial level. While the channel is stopped, the output follows later changes to the initial level one clock after each write.
- R10: The interrupt flag is set on every WRAP and holds until a write of 1 to bit0 of address 5 clears it. If a set and a clear fall in the same clock, the set wins.
- R11: `irq` is the interrupt flag gated by the interrupt enable. A flag that is pending while the enable is off appears on `irq` one clock after the enable is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_chan | input | CHAN_W | Channel index of the write |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | 8 | Write data byte |
| pwm_out | output | 1 | Modulated output |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after several corner cases:
- A comparator at 0. A design that only compares against counter+1 would miss this toggle after START and after WRAP.
- Duplicate comparator values. A design that ORs the hits instead of XORing them would toggle once instead of cancelling.
- Comparators that are disabled or lie beyond the period. A design with a leaky guard would add spurious edges.
- A rewrite in the middle of a period. A design without shadow registers would glitch before the boundary.
- Prescale values of 0 and 255. An off-by-one in the divider would stretch or shrink every step.
- A write on a foreign channel index, including a stop command. A design with a loose decode would alter the waveform or halt the output.
- An interrupt flag that is pending while the enable is off. A design that gated the set instead of the output would lose the event.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;
    localparam int PWM_CNT_W = 16;
    localparam int PWM_PS_W  = 8;
    localparam int PWM_NCMP  = 8;

    localparam int A_CTRL     = 0;
    localparam int A_PRESC    = 1;
    localparam int A_PER_LO   = 2;
    localparam int A_PER_HI   = 3;
    localparam int A_CMP_EN   = 4;
    localparam int A_IRQ_CLR  = 5;
    localparam int A_CMP_BASE = 8;

    localparam int PWM_ADDR_W = $clog2(A_CMP_BASE + 2 * PWM_NCMP);

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    typedef struct packed {
        logic irq_en;
        logic init_lvl;
        logic run;
    } ctrl_t;
endpackage

// File: rtl/tpwm_regs.sv
module tpwm_regs
    import tpwm_pkg::*;
#(
    parameter int NCMP    = PWM_NCMP,
    parameter int CNT_W   = PWM_CNT_W,
    parameter int PS_W    = PWM_PS_W,
    parameter int ADDR_W  = PWM_ADDR_W,
    parameter int CHAN_W  = 3,
    parameter int CHAN_ID = 0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [CHAN_W-1:0]           wr_chan,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [7:0]                  wr_data,
    output ctrl_t                       ctrl_o,
    output logic [PS_W-1:0]             presc_o,
    output logic [CNT_W-1:0]            period_o,
    output logic [NCMP-1:0]             cmp_en_o,
    output logic [NCMP-1:0][CNT_W-1:0]  cmp_o,
    output logic                        irq_clr_o
);
    localparam int HI_W = CNT_W - 8;

    logic sel;
    assign sel = wr_en && (wr_chan == CHAN_W'(CHAN_ID));

    // The clear strobe is decoded from the bus directly so it acts in the write cycle.
    assign irq_clr_o = sel && (wr_addr == ADDR_W'(A_IRQ_CLR)) && wr_data[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_o   <= '0;
            presc_o  <= '0;
            period_o <= '0;
            cmp_en_o <= '0;
            cmp_o    <= '0;
        end else if (sel) begin
            if (wr_addr == ADDR_W'(A_CTRL))   ctrl_o               <= ctrl_t'(wr_data[2:0]);
            if (wr_addr == ADDR_W'(A_PRESC))  presc_o              <= wr_data[PS_W-1:0];
            if (wr_addr == ADDR_W'(A_PER_LO)) period_o[7:0]        <= wr_data;
            if (wr_addr == ADDR_W'(A_PER_HI)) period_o[CNT_W-1:8]  <= wr_data[HI_W-1:0];
            if (wr_addr == ADDR_W'(A_CMP_EN)) cmp_en_o             <= wr_data[NCMP-1:0];
            for (int k = 0; k < NCMP; k++) begin
                if (wr_addr == ADDR_W'(A_CMP_BASE + 2 * k))
                    cmp_o[k][7:0] <= wr_data;
                if (wr_addr == ADDR_W'(A_CMP_BASE + 2 * k + 1))
                    cmp_o[k][CNT_W-1:8] <= wr_data[HI_W-1:0];
            end
        end
    end
endmodule

// File: rtl/tpwm_prescaler.sv
module tpwm_prescaler #(
    parameter int PS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic [PS_W-1:0] div,
    output logic            tick
);
    logic [PS_W-1:0] cnt_q;

    assign tick = !clear && (cnt_q == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt_q <= '0;
        else if (clear)       cnt_q <= '0;
        else if (cnt_q == div) cnt_q <= '0;
        else                  cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/tpwm_cmp_bank.sv
module tpwm_cmp_bank #(
    parameter int NCMP  = 8,
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0]           probe,
    input  logic [CNT_W-1:0]           limit,
    input  logic [NCMP-1:0]            en,
    input  logic [NCMP-1:0][CNT_W-1:0] vals,
    output logic                       parity
);
    logic [NCMP-1:0] hit;

    for (genvar k = 0; k < NCMP; k++) begin : g_cmp
        assign hit[k] = en[k] && (vals[k] == probe) && (vals[k] <= limit);
    end

    // Matching comparators are XORed, so equal values cancel each other.
    assign parity = ^hit;
endmodule

// File: rtl/tpwm_channel.sv
module tpwm_channel
    import tpwm_pkg::*;
#(
    parameter int NCMP    = PWM_NCMP,
    parameter int CNT_W   = PWM_CNT_W,
    parameter int PS_W    = PWM_PS_W,
    parameter int ADDR_W  = PWM_ADDR_W,
    parameter int CHAN_W  = 3,
    parameter int CHAN_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CHAN_W-1:0] wr_chan,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              pwm_out,
    output logic              irq
);
    // Live register values
    ctrl_t                      ctrl;
    logic [PS_W-1:0]            presc_live;
    logic [CNT_W-1:0]           per_live;
    logic [NCMP-1:0]            en_live;
    logic [NCMP-1:0][CNT_W-1:0] cmp_live;
    logic                       irq_clr;

    // Shadow values used while running
    logic [PS_W-1:0]            ps_sh;
    logic [CNT_W-1:0]           per_sh;
    logic [NCMP-1:0]            en_sh;
    logic [NCMP-1:0][CNT_W-1:0] cmp_sh;

    run_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic             out_q;
    logic             irq_stat;
    logic             tick;
    logic             par_zero, par_next;
    logic             start, wrap, step, load;

    tpwm_regs #(
        .NCMP(NCMP), .CNT_W(CNT_W), .PS_W(PS_W), .ADDR_W(ADDR_W),
        .CHAN_W(CHAN_W), .CHAN_ID(CHAN_ID)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_chan   (wr_chan),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ctrl_o    (ctrl),
        .presc_o   (presc_live),
        .period_o  (per_live),
        .cmp_en_o  (en_live),
        .cmp_o     (cmp_live),
        .irq_clr_o (irq_clr)
    );

    tpwm_prescaler #(.PS_W(PS_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear ((st_q != ST_RUN) || !ctrl.run),
        .div   (ps_sh),
        .tick  (tick)
    );

    // Comparators against counter zero, using the values about to become shadows.
    tpwm_cmp_bank #(.NCMP(NCMP), .CNT_W(CNT_W)) u_cmp_zero (
        .probe  ('0),
        .limit  (per_live),
        .en     (en_live),
        .vals   (cmp_live),
        .parity (par_zero)
    );

    // Comparators against the next counter value, using the active shadows.
    tpwm_cmp_bank #(.NCMP(NCMP), .CNT_W(CNT_W)) u_cmp_next (
        .probe  (cnt_q + 1'b1),
        .limit  (per_sh),
        .en     (en_sh),
        .vals   (cmp_sh),
        .parity (par_next)
    );

    assign start = (st_q == ST_IDLE) && ctrl.run;
    assign wrap  = (st_q == ST_RUN) && ctrl.run && tick && (cnt_q == per_sh);
    assign step  = (st_q == ST_RUN) && ctrl.run && tick && (cnt_q != per_sh);
    assign load  = start || wrap;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Transitions: START, STOP (WRAP stays in ST_RUN)
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (ctrl.run)  st_d = ST_RUN;
            ST_RUN:  if (!ctrl.run) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // Counter, output level, shadows and interrupt flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            out_q    <= 1'b0;
            ps_sh    <= '0;
            per_sh   <= '0;
            en_sh    <= '0;
            cmp_sh   <= '0;
            irq_stat <= 1'b0;
        end else begin
            if (load) begin
                ps_sh  <= presc_live;
                per_sh <= per_live;
                en_sh  <= en_live;
                cmp_sh <= cmp_live;
            end
            unique case (st_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    out_q <= ctrl.init_lvl ^ (ctrl.run & par_zero);
                end
                ST_RUN: begin
                    if (!ctrl.run) begin
                        cnt_q <= '0;
                        out_q <= ctrl.init_lvl;
                    end else if (wrap) begin
                        cnt_q <= '0;
                        out_q <= ctrl.init_lvl ^ par_zero;
                    end else if (step) begin
                        cnt_q <= cnt_q + 1'b1;
                        out_q <= out_q ^ par_next;
                    end
                end
                default: begin
                    cnt_q <= '0;
                    out_q <= ctrl.init_lvl;
                end
            endcase
            if (wrap)         irq_stat <= 1'b1;
            else if (irq_clr) irq_stat <= 1'b0;
        end
    end

    assign pwm_out = out_q;
    assign irq     = irq_stat && ctrl.irq_en;
endmodule

// File: rtl/tpwm_channel_sva.sv
module tpwm_channel_sva #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             st_run,
    input logic             run,
    input logic             init_lvl,
    input logic             irq_en,
    input logic             tick,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] per_sh,
    input logic             pwm_out,
    input logic             irq,
    input logic             irq_stat,
    input logic             irq_clr
);
    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_run |-> count <= per_sh); // R3

    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_run && run && !tick) |=> ($stable(pwm_out) && $stable(count))); // R2

    AST_TICK_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_run && run && tick && count != per_sh) |=> count == CNT_W'($past(count) + 1'b1)); // R2

    AST_STOP_TO_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> pwm_out == $past(init_lvl)); // R9

    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (st_run && run && tick && count == per_sh) |=> (count == '0) && irq_stat); // R10

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_stat && !irq_clr) |=> irq_stat); // R10

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq); // R11
endmodule

bind tpwm_channel tpwm_channel_sva #(.CNT_W(CNT_W)) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_run   (st_q == ST_RUN),
    .run      (ctrl.run),
    .init_lvl (ctrl.init_lvl),
    .irq_en   (ctrl.irq_en),
    .tick     (tick),
    .count    (cnt_q),
    .per_sh   (per_sh),
    .pwm_out  (pwm_out),
    .irq      (irq),
    .irq_stat (irq_stat),
    .irq_clr  (irq_clr)
);

// File: tb/tpwm_channel_test.sv
module tpwm_channel_test;
    localparam int CLK_P   = 10;
    localparam int CHAN_ID = 3;

    typedef struct packed {
        logic [15:0]      per;
        logic [7:0]       ps;
        logic             init;
        logic [7:0]       en;
        logic [7:0][15:0] cmp;
    } pcfg_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_chan = '0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       pwm_out, irq;

    int    errors = 0;
    int    n_chk  = 0;
    int    cyc    = 0;
    int    epoch  = 0;
    bit    chk_on = 1'b0;
    bit    done   = 1'b0;
    string cur_req = "R5";
    pcfg_t cfg_a, cfg_b;

    tpwm_channel #(.CHAN_ID(CHAN_ID)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan),
        .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out), .irq(irq)
    );

    always #(CLK_P / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int plen(pcfg_t c);
        return (int'(c.per) + 1) * (int'(c.ps) + 1);
    endfunction

    function automatic logic level_at(pcfg_t c, int t);
        int   k = (t / (int'(c.ps) + 1)) % (int'(c.per) + 1);
        logic o = c.init;
        for (int i = 0; i < 8; i++)
            if (c.en[i] && c.cmp[i] <= c.per && int'(c.cmp[i]) <= k) o = ~o;
        return o;
    endfunction

    function automatic logic expect_at(int t);
        if (t < plen(cfg_a)) return level_at(cfg_a, t);
        return level_at(cfg_b, t - plen(cfg_a));
    endfunction

    task automatic check(string req, int act, int expv);
        n_chk++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // Cycle-by-cycle comparison of the output against the reference waveform
    always @(negedge clk) begin
        if (chk_on && rst_n && (cyc >= epoch))
            check(cur_req, int'(pwm_out), int'(expect_at(cyc - epoch)));
    end

    task automatic wr(input logic [2:0] ch, input int a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_chan = ch; wr_addr = 5'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic prog(pcfg_t c, logic [2:0] ch);
        wr(ch, 1, c.ps);
        wr(ch, 2, c.per[7:0]);
        wr(ch, 3, c.per[15:8]);
        wr(ch, 4, c.en);
        for (int i = 0; i < 8; i++) begin
            wr(ch, 8 + 2 * i, c.cmp[i][7:0]);
            wr(ch, 9 + 2 * i, c.cmp[i][15:8]);
        end
    endtask

    task automatic start(pcfg_t c, bit ien, string req);
        chk_on = 1'b0;
        wr(3'(CHAN_ID), 0, {5'd0, 1'b0, c.init, 1'b0});
        wr(3'(CHAN_ID), 5, 8'h01);
        prog(c, 3'(CHAN_ID));
        cfg_a = c; cfg_b = c;
        cur_req = req;
        wr(3'(CHAN_ID), 0, {5'd0, ien, c.init, 1'b1});
        epoch  = cyc + 1;
        chk_on = 1'b1;
    endtask

    task automatic wait_t(int tgt);
        while (cyc - epoch < tgt) @(negedge clk);
    endtask

    function automatic pcfg_t rand_cfg();
        pcfg_t c;
        c.per  = 16'($urandom_range(3, 40));
        c.ps   = 8'($urandom_range(0, 3));
        c.init = 1'($urandom_range(0, 1));
        c.en   = 8'($urandom_range(0, 255));
        for (int i = 0; i < 8; i++) c.cmp[i] = 16'($urandom_range(0, int'(c.per) + 6));
        return c;
    endfunction

    initial begin
        #(CLK_P * 190000);
        if (!done) begin
            errors++; n_chk++;
            $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
            $display("Result: errors=%0d of %0d checks", errors, n_chk);
            $finish;
        end
    end

    initial begin
        pcfg_t c, b;
        int    rises;
        logic  prev;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset level", int'(pwm_out), 0);
        check("R11 reset irq", int'(irq), 0);

        // R5 worked example: toggles at 7 8 12 14 15 16 19 22 give four pulses
        c = '0; c.per = 25; c.ps = 1; c.init = 1'b0; c.en = 8'hFF;
        c.cmp[0] = 7;  c.cmp[1] = 8;  c.cmp[2] = 12; c.cmp[3] = 14;
        c.cmp[4] = 15; c.cmp[5] = 16; c.cmp[6] = 19; c.cmp[7] = 22;
        start(c, 1'b1, "R5");
        wait_t(0);
        prev = pwm_out; rises = 0;
        for (int i = 1; i < 52; i++) begin
            @(negedge clk);
            if (pwm_out && !prev) rises++;
            prev = pwm_out;
        end
        check("R5 pulse count", rises, 4);
        check("R10 flag before wrap", int'(irq), 0);
        wait_t(52);
        check("R10 flag at wrap", int'(irq), 1);
        wait_t(55);
        wr(3'(CHAN_ID), 5, 8'h01);
        check("R10 flag cleared", int'(irq), 0);
        wr(3'(CHAN_ID), 0, 8'b001);
        wait_t(105);
        check("R11 masked pending flag", int'(irq), 0);
        wr(3'(CHAN_ID), 0, 8'b101);
        check("R11 pending flag revealed", int'(irq), 1);

        // R9 stop: output goes to the initial level and follows it while stopped
        chk_on = 1'b0;
        wr(3'(CHAN_ID), 0, 8'b010);
        @(negedge clk);
        check("R9 stop level", int'(pwm_out), 1);
        repeat (3) @(negedge clk);
        check("R9 stays stopped", int'(pwm_out), 1);
        wr(3'(CHAN_ID), 0, 8'b000);
        @(negedge clk);
        check("R9 idle follows init", int'(pwm_out), 0);

        // R4/R7: comparator at zero flips the start level and every wrap level
        c = '0; c.per = 4; c.ps = 0; c.init = 1'b0; c.en = 8'h01; c.cmp[0] = 0;
        start(c, 1'b0, "R7");
        wait_t(0);
        check("R4 start level with zero comparator", int'(pwm_out), 1);
        wait_t(5);
        check("R7 wrap level with zero comparator", int'(pwm_out), 1);
        wait_t(12);

        // R6: duplicates cancel, disabled and beyond-period comparators are inert
        c = '0; c.per = 12; c.ps = 0; c.init = 1'b1; c.en = 8'b0000_1111;
        c.cmp[0] = 5; c.cmp[1] = 5; c.cmp[2] = 9; c.cmp[3] = 20; c.cmp[4] = 3;
        start(c, 1'b0, "R6");
        wait_t(3);
        check("R6 disabled comparator", int'(pwm_out), 1);
        wait_t(6);
        check("R6 duplicate values cancel", int'(pwm_out), 1);
        wait_t(9);
        check("R6 single toggle", int'(pwm_out), 0);
        wait_t(12);
        check("R6 beyond-period comparator", int'(pwm_out), 0);
        wait_t(30);

        // R2: largest prescale
        c = '0; c.per = 2; c.ps = 255; c.init = 1'b0; c.en = 8'h01; c.cmp[0] = 1;
        start(c, 1'b0, "R2");
        wait_t(255);
        check("R2 before first tick", int'(pwm_out), 0);
        wait_t(256);
        check("R2 first tick at 256", int'(pwm_out), 1);
        wait_t(800);

        // R8: mid-period rewrite only acts at the boundary
        c = '0; c.per = 30; c.ps = 3; c.init = 1'b0; c.en = 8'h03; c.cmp[0] = 4; c.cmp[1] = 20;
        start(c, 1'b0, "R8");
        wait_t(5);
        b = '0; b.per = 9; b.ps = 1; b.init = 1'b1; b.en = 8'h06; b.cmp[1] = 2; b.cmp[2] = 6;
        cfg_b = b;
        prog(b, 3'(CHAN_ID));
        wr(3'(CHAN_ID), 0, {5'd0, 1'b0, b.init, 1'b1});
        check("R8 rewrite finished inside period", int'(cyc - epoch < plen(c)), 1);
        wait_t(plen(c) + 2 * plen(b));

        // R1: writes for another channel are ignored, including a stop
        c = '0; c.per = 15; c.ps = 1; c.init = 1'b0; c.en = 8'h05; c.cmp[0] = 3; c.cmp[2] = 9;
        start(c, 1'b0, "R1");
        wait_t(3);
        b = '0; b.per = 2; b.en = 8'hFF;
        prog(b, 3'd5);
        wr(3'd5, 0, 8'b010);
        wait_t(2 * plen(c) + 5);

        // R3: constrained random configurations
        for (int n = 0; n < 10; n++) begin
            c = rand_cfg();
            start(c, 1'b0, "R3");
            wait_t(2 * plen(c) + 3);
        end

        chk_on = 1'b0;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, n_chk);
        $finish;
    end
endmodule